// File: doc/BRIEF.md
# Cascadable Serial-Loaded Channel Latch

This block takes an eight-bit channel word over a three-wire serial link and holds it on eight active-high channel-enable outputs. The link's clock, select and data lines arrive asynchronously. A fast system clock samples them and finds the link-clock and select edges from the samples. While the select line is low, each rising link-clock edge shifts one data bit into an internal shift register. When the select line rises, the shift register is copied into the output latch in one step.

The last stage of the shift register is driven out on a serial output pin. This pin changes on falling link-clock edges. Wiring one unit's serial output to the next unit's data input, with clock and select shared, makes a longer chain. A burst of 8×N bits then updates all N units together when the shared select rises.

Two active-low override inputs act on every stage. One force-on input sets the shift register, the serial output and the latch to ones. One force-off input clears them, and force-off always wins.

Top module: `cascade_out_latch`

## Requirements
- R1: While the select input is low, each rising edge of the link clock shifts the register one place toward its top bit and enters the data input at bit 0.
- R2: While the select input is high, link-clock and data transitions change neither the register, the serial output nor the channel outputs.
- R3: The word is sent top bit first: in an 8-bit burst the first bit ends on chan_en_o[7] and the last on chan_en_o[0].
- R4: The channel outputs hold their value for as long as the select input stays low.
- R5: On each falling link-clock edge while selected, the serial output takes the register's top bit. In a chain of two units, a 16-bit burst leaves the first byte in the far unit and the second byte in the near unit.
- R6: A burst of 7 or of 9 bits leaves the register holding the 8 most recently shifted bits. With 7 bits, the register's old bit 0 moves to bit 7. With 9 bits, the first bit is lost.
- R7: Holding force-on low sets the register, the serial output and all channel outputs to one by the third rising system-clock edge, whatever the serial inputs do.
- R8: Holding force-off low clears the register, the serial output and all channel outputs. It takes precedence over force-on and over every serial input.
- R9: Releasing an override changes nothing by itself. The next select rise loads whatever the register then holds.
- R10: After reset, all channel outputs and the serial output are zero.
- R11: A select rise loads the latch whatever the link-clock level is at that moment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least four times the link-clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk_i | input | 1 | Serial link clock |
| sel_ni | input | 1 | Active-low select; its rising edge loads the latch |
| sdi_i | input | 1 | Serial data input |
| all_on_ni | input | 1 | Active-low force-on override |
| all_off_ni | input | 1 | Active-low force-off override, dominant |
| sdo_o | output | 1 | Serial output, last register stage, for cascading |
| chan_en_o | output | CH_W | Active-high channel enables |

## Verification
A wrong bit in the shift register is hidden while select is low. It shows on the serial output at most eight link-clock falls later, and on the channel outputs at the next select rise. In a chain it reaches the far unit's channels at the same select rise. A wrong override priority or latency shows on all eight channels within three system clocks of the override edge. A reference model steps through every system clock, including the synchronizer delay, so a shift or load that happens one sample early or late is caught in the cycle it happens.

// File: rtl/col_pkg.sv
package col_pkg;

  // Inputs that need edge detection
  localparam int unsigned EDGE_PINS = 2;
  localparam int unsigned EP_SCLK   = 0;
  localparam int unsigned EP_SEL    = 1;
  // Idle levels: link clock low, select high
  localparam logic [EDGE_PINS-1:0] EDGE_IDLE = 2'b10;

  // Inputs used only as levels
  localparam int unsigned LEVEL_PINS = 3;
  localparam int unsigned LP_DIN     = 0;
  localparam int unsigned LP_ON      = 1;
  localparam int unsigned LP_OFF     = 2;
  // Idle levels: data low, both overrides released
  localparam logic [LEVEL_PINS-1:0] LEVEL_IDLE = 3'b110;

  typedef enum logic [1:0] {
    FRC_NONE = 2'd0,
    FRC_ON   = 2'd1,
    FRC_OFF  = 2'd2
  } force_e;

  // Force-off dominates force-on
  function automatic force_e pick_force(input logic on_n, input logic off_n);
    if (!off_n) return FRC_OFF;
    if (!on_n)  return FRC_ON;
    return FRC_NONE;
  endfunction

endpackage

// File: rtl/col_sync.sv
module col_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{IDLE}};
    else         pipe_q <= pipe_d;
  end

  assign lvl_o = pipe_q[STAGES-1];
endmodule

// File: rtl/col_edge.sv
module col_edge #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic prev_o
);
  logic lvl;
  logic prev_q;

  col_sync #(.STAGES(STAGES), .IDLE(IDLE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (d_i),
    .lvl_o (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= IDLE;
    else         prev_q <= lvl;
  end

  assign lvl_o  = lvl;
  assign prev_o = prev_q;
endmodule

// File: rtl/col_shift.sv
module col_shift
  import col_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_low_i,
  input  logic         sclk_rise_i,
  input  logic         sclk_fall_i,
  input  logic         din_i,
  input  force_e       frc_i,
  output logic [W-1:0] sr_o,
  output logic         sdo_o
);
  localparam int unsigned TOP = W - 1;

  logic [W-1:0] sr_q, sr_d;
  logic         sdo_q, sdo_d;
  logic         en;

  always_comb begin
    sr_d  = sr_q;
    sdo_d = sdo_q;
    unique case (frc_i)
      FRC_OFF: begin
        sr_d  = '0;
        sdo_d = 1'b0;
      end
      FRC_ON: begin
        sr_d  = '1;
        sdo_d = 1'b1;
      end
      default: begin
        if (sel_low_i && sclk_rise_i) sr_d  = {sr_q[TOP-1:0], din_i};
        if (sel_low_i && sclk_fall_i) sdo_d = sr_q[TOP];
      end
    endcase
  end

  assign en = (frc_i != FRC_NONE) | (sel_low_i & (sclk_rise_i | sclk_fall_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      sdo_q <= 1'b0;
    end else if (en) begin
      sr_q  <= sr_d;
      sdo_q <= sdo_d;
    end
  end

  assign sr_o  = sr_q;
  assign sdo_o = sdo_q;

  // R1
  shift_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_low_i && sclk_rise_i && frc_i == FRC_NONE)
      |=> (sr_q[TOP:1] == $past(sr_q[TOP-1:0]) && sr_q[0] == $past(din_i)));

  // R2
  idle_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_low_i && frc_i == FRC_NONE) |=> ($stable(sr_q) && $stable(sdo_q)));

  // R5
  sdo_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_low_i && sclk_fall_i && frc_i == FRC_NONE) |=> (sdo_q == $past(sr_q[TOP])));
endmodule

// File: rtl/col_hold.sv
module col_hold
  import col_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_rise_i,
  input  force_e       frc_i,
  input  logic [W-1:0] sr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;
  logic         en;

  always_comb begin
    q_d = q_q;
    unique case (frc_i)
      FRC_OFF: q_d = '0;
      FRC_ON:  q_d = '1;
      default: if (sel_rise_i) q_d = sr_i;
    endcase
  end

  assign en = (frc_i != FRC_NONE) | sel_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q_q <= '0;
    else if (en)  q_q <= q_d;
  end

  assign q_o = q_q;

  // R11
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_rise_i && frc_i == FRC_NONE) |=> (q_q == $past(sr_i)));
endmodule

// File: rtl/cascade_out_latch.sv
module cascade_out_latch
  import col_pkg::*;
#(
  parameter int unsigned CH_W        = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sclk_i,
  input  logic            sel_ni,
  input  logic            sdi_i,
  input  logic            all_on_ni,
  input  logic            all_off_ni,
  output logic            sdo_o,
  output logic [CH_W-1:0] chan_en_o
);
  // Reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  // Input sampling
  logic [EDGE_PINS-1:0]  edge_raw, edge_lvl, edge_prev;
  logic [LEVEL_PINS-1:0] level_raw, level_lvl;

  assign edge_raw[EP_SCLK]  = sclk_i;
  assign edge_raw[EP_SEL]   = sel_ni;
  assign level_raw[LP_DIN]  = sdi_i;
  assign level_raw[LP_ON]   = all_on_ni;
  assign level_raw[LP_OFF]  = all_off_ni;

  for (genvar g = 0; g < EDGE_PINS; g++) begin : g_edge
    col_edge #(.STAGES(SYNC_STAGES), .IDLE(EDGE_IDLE[g])) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_n),
      .d_i   (edge_raw[g]),
      .lvl_o (edge_lvl[g]),
      .prev_o(edge_prev[g])
    );
  end

  for (genvar g = 0; g < LEVEL_PINS; g++) begin : g_level
    col_sync #(.STAGES(SYNC_STAGES), .IDLE(LEVEL_IDLE[g])) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_n),
      .d_i   (level_raw[g]),
      .lvl_o (level_lvl[g])
    );
  end

  // Decoded controls
  logic   sclk_rise, sclk_fall, sel_low, sel_rise;
  force_e frc;

  assign sclk_rise = edge_lvl[EP_SCLK] & ~edge_prev[EP_SCLK];
  assign sclk_fall = ~edge_lvl[EP_SCLK] & edge_prev[EP_SCLK];
  assign sel_low   = ~edge_lvl[EP_SEL];
  assign sel_rise  = edge_lvl[EP_SEL] & ~edge_prev[EP_SEL];
  assign frc       = pick_force(level_lvl[LP_ON], level_lvl[LP_OFF]);

  logic [CH_W-1:0] sr;

  col_shift #(.W(CH_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .sel_low_i  (sel_low),
    .sclk_rise_i(sclk_rise),
    .sclk_fall_i(sclk_fall),
    .din_i      (level_lvl[LP_DIN]),
    .frc_i      (frc),
    .sr_o       (sr),
    .sdo_o      (sdo_o)
  );

  col_hold #(.W(CH_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .sel_rise_i(sel_rise),
    .frc_i     (frc),
    .sr_i      (sr),
    .q_o       (chan_en_o)
  );

  // R4
  hold_sel_low_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sel_low && frc == FRC_NONE) |=> $stable(chan_en_o));

  // R7
  force_on_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (level_lvl[LP_OFF] && !level_lvl[LP_ON]) |=> (chan_en_o == '1 && sdo_o));

  // R8
  force_off_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!level_lvl[LP_OFF]) |=> (chan_en_o == '0 && !sdo_o));
endmodule

// File: tb/test_cascade_out_latch.sv
module test_cascade_out_latch;
  localparam int W = 8;
  localparam logic [4:0] IDLE = 5'b11010; // {off_n, on_n, din, sel_n, sclk}

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sclk, sel_n, sdi, on_n, off_n;
  logic mid, sdo_far;
  logic [W-1:0] en_near, en_far;

  cascade_out_latch i_cascade_out_latch (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sel_ni(sel_n), .sdi_i(sdi),
    .all_on_ni(on_n), .all_off_ni(off_n), .sdo_o(mid), .chan_en_o(en_near));

  cascade_out_latch i_cascade_out_latch_far (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sel_ni(sel_n), .sdi_i(mid),
    .all_on_ni(on_n), .all_off_ni(off_n), .sdo_o(sdo_far), .chan_en_o(en_far));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference: per unit, input history and state
  logic [4:0]   hist  [2][4];
  logic [W-1:0] m_sr  [2];
  logic [W-1:0] m_lat [2];
  logic         m_do  [2];
  logic [4:0]   in_now[2];
  logic [4:0]   a, b;
  logic [W-1:0] old_sr;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int u = 0; u < 2; u++) begin
        for (int k = 0; k < 4; k++) hist[u][k] = IDLE;
        m_sr[u] = '0; m_lat[u] = '0; m_do[u] = 1'b0;
      end
    end else begin
      in_now[0] = {off_n, on_n, sdi, sel_n, sclk};
      in_now[1] = {off_n, on_n, m_do[0], sel_n, sclk};
      for (int u = 0; u < 2; u++) begin
        for (int k = 3; k > 0; k--) hist[u][k] = hist[u][k-1];
        hist[u][0] = in_now[u];
        a = hist[u][2];
        b = hist[u][3];
        if (!a[4]) begin
          m_sr[u] = '0; m_lat[u] = '0; m_do[u] = 1'b0;
        end else if (!a[3]) begin
          m_sr[u] = '1; m_lat[u] = '1; m_do[u] = 1'b1;
        end else begin
          old_sr = m_sr[u];
          if (!a[1] && a[0] && !b[0]) m_sr[u] = {old_sr[W-2:0], a[2]};
          if (!a[1] && !a[0] && b[0]) m_do[u] = old_sr[W-1];
          if (a[1] && !b[1])          m_lat[u] = old_sr;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done)
      chk("R1 R4 R5 R7 R8 model",
          {14'd0, sdo_far, mid, en_far, en_near},
          {14'd0, m_do[1], m_do[0], m_lat[1], m_lat[0]});
  end

  // Stimulus helpers
  logic [15:0] chain_exp;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n, input bit leave_high = 1'b0);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      wait_clk(6);
      sclk = 1'b1;
      wait_clk(6);
      if (!(leave_high && i == 0)) sclk = 1'b0;
      chain_exp = {chain_exp[14:0], bits[i]};
    end
  endtask

  task automatic burst(input logic [31:0] bits, input int n);
    sel_n = 1'b0;
    wait_clk(6);
    shift_bits(bits, n);
    wait_clk(6);
    sel_n = 1'b1;
    wait_clk(6);
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; sel_n = 1'b1; sdi = 1'b0; on_n = 1'b1; off_n = 1'b1;
    chain_exp = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R10 reset state
    chk("R10 near channels", en_near, 0);
    chk("R10 far channels", en_far, 0);
    chk("R10 serial outputs", {mid, sdo_far}, 0);

    // R1 R3 single byte
    burst(32'hA5, 8);
    chk("R1 near word", en_near, 8'hA5);
    chk("R3 first bit on top channel", en_near[7], 1'b1);
    chk("R3 last bit on channel 0", en_near[0], 1'b1);

    // R5 cascade 16-bit
    burst(32'h3C96, 16);
    chk("R5 far unit gets first byte", en_far, 8'h3C);
    chk("R5 near unit gets second byte", en_near, 8'h96);

    // R4 hold while selected
    sel_n = 1'b0;
    wait_clk(6);
    shift_bits(32'h0F, 8);
    wait_clk(6);
    chk("R4 near held while select low", en_near, 8'h96);
    chk("R4 far held while select low", en_far, 8'h3C);
    sel_n = 1'b1;
    wait_clk(6);
    chk("R4 near after select rise", en_near, chain_exp[7:0]);
    chk("R5 near serial out is top bit", mid, chain_exp[7]);
    chk("R5 far serial out is top bit", sdo_far, chain_exp[15]);

    // R2 clock and data ignored while deselected
    for (int i = 0; i < 6; i++) begin
      sdi = i[0];
      wait_clk(6); sclk = 1'b1;
      wait_clk(6); sclk = 1'b0;
    end
    wait_clk(6);
    chk("R2 serial outs unchanged", {mid, sdo_far}, {chain_exp[7], chain_exp[15]});
    sel_n = 1'b0; wait_clk(6); sel_n = 1'b1; wait_clk(6);
    chk("R2 near register unchanged", en_near, chain_exp[7:0]);
    chk("R2 far register unchanged", en_far, chain_exp[15:8]);

    // R6 short and long bursts
    burst(32'h13, 7);
    chk("R6 seven-bit near", en_near, chain_exp[7:0]);
    chk("R6 seven-bit far", en_far, chain_exp[15:8]);
    burst(32'h1C5, 9);
    chk("R6 nine-bit near", en_near, chain_exp[7:0]);
    chk("R6 nine-bit far", en_far, chain_exp[15:8]);

    // R7 force-on within three edges
    on_n = 1'b0;
    wait_clk(3);
    chk("R7 near all on", en_near, 8'hFF);
    chk("R7 far all on", en_far, 8'hFF);
    chk("R7 serial outs high", {mid, sdo_far}, 2'b11);
    on_n = 1'b1;
    wait_clk(6);
    chain_exp = 16'hFFFF;
    sel_n = 1'b0; wait_clk(6); sel_n = 1'b1; wait_clk(6);
    chk("R9 load after force-on release", {en_far, en_near}, 16'hFFFF);

    // R8 force-off dominates
    off_n = 1'b0; on_n = 1'b0;
    wait_clk(4);
    chk("R8 both overrides, channels off", {en_far, en_near}, 16'h0000);
    chk("R8 serial outs low", {mid, sdo_far}, 2'b00);
    sel_n = 1'b0; wait_clk(6);
    shift_bits(32'hFF, 8);
    wait_clk(6); sel_n = 1'b1; wait_clk(6);
    chk("R8 serial burst ignored", {en_far, en_near}, 16'h0000);
    on_n = 1'b1; wait_clk(6);
    chk("R8 still off with force-on released", en_near, 8'h00);
    off_n = 1'b1; wait_clk(6);
    chain_exp = 16'h0000;
    sel_n = 1'b0; wait_clk(6); sel_n = 1'b1; wait_clk(6);
    chk("R9 load after force-off release", {en_far, en_near}, 16'h0000);

    // R11 load with link clock high
    sel_n = 1'b0; wait_clk(6);
    shift_bits(32'h5A, 8, 1'b1);
    wait_clk(6);
    sel_n = 1'b1;
    wait_clk(6);
    chk("R11 near load with clock high", en_near, 8'h5A);
    chk("R11 far load with clock high", en_far, chain_exp[15:8]);
    sclk = 1'b0;
    wait_clk(6);
    chk("R11 near stable after late fall", en_near, 8'h5A);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule